// File: doc/BRIEF.md
# DMA Event and Interrupt Unit

This block holds the sixteen event resources that the threads of a DMA engine share for signalling. A thread that issues a send-event command names one resource. A per-resource role bit decides what the command does. If the bit is clear, the command raises an internal event flag, which another thread can pick up to trigger across channels or from the manager to a channel. If the bit is set, the command raises a sticky interrupt status bit instead. Only resources 0 to 7 have a role bit. Resources 8 to 15 always act as internal events. Each interrupt status bit drives two identical outputs, one per destination. Software clears a status bit by writing a one to it.

Each waiting thread has a slot, and each slot is a small state machine with two states. `SLOT_IDLE` takes the transition *park* on a wait command and stores the resource number. `SLOT_PARKED` takes the transition *release* in the first cycle in which the stored resource is seen set. That happens when its flag is already up, or when a send-event to it arrives in that same cycle. On *release* the slot pulses its done line and returns to `SLOT_IDLE`, and the unit clears the flag once. All slots parked on the same resource are released together.

Top module: `dma_evt_unit`

## Requirements
- R1: A send-event (`sev_valid`, `sev_id` = resource number 0..15) to a resource whose role bit is clear sets bit `sev_id` of `evt_flags` on the next clock edge. The flag then stays set until a waiter consumes it.
- R2: A write (`en_we`) stores `en_wdata[7:0]` as the role bits of resources 0..7. `en_rd[15:8]` always reads zero, so a send-event to resources 8..15 always sets a flag.
- R3: A send-event to a resource 0..7 whose role bit is set sets bit `sev_id` of the interrupt status on the next edge and leaves `evt_flags` unchanged.
- R4: `irq_ps` and `irq_pl` both carry the interrupt status and are equal in every cycle.
- R5: An interrupt status bit stays set until a write with `irq_clr_we` high has a one in that bit of `irq_clr_mask`. If a set and a clear reach the same bit in the same cycle, the bit ends up set.
- R6: A wait command (`wfe_go[t]` with resource `wfe_id[4t+3:4t]`) parks slot t from the next edge. While parked, `wfe_done[t]` is high, in the same cycle, exactly when the resource's flag is set or a send-event to it is present. The slot is then idle from the next edge and the flag is clear.
- R7: All slots parked on the same resource are released in the same cycle, and the flag is cleared once.
- R8: If a send-event and a release hit the same resource in the same cycle, the waiters are released and the flag stays clear.
- R9: A wait command to a slot that is already parked is ignored. The slot keeps its original resource.
- R10: After reset, the role bits, the flags and the interrupt status are zero and every slot is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_we | input | 1 | Write strobe for the role bits |
| en_wdata | input | 8 | New role bits for resources 0..7 (1 = interrupt) |
| irq_clr_we | input | 1 | Write strobe for clearing interrupt status |
| irq_clr_mask | input | 8 | Write-one-to-clear mask for the interrupt status |
| sev_valid | input | 1 | Send-event command present |
| sev_id | input | 4 | Resource named by the send-event |
| wfe_go | input | 9 | Wait command, one bit per thread |
| wfe_id | input | 36 | Resource per thread, 4 bits each, thread t at [4t+3:4t] |
| wfe_done | output | 9 | Release pulse, one bit per thread |
| en_rd | output | 16 | Role-bit readback, bits 15..8 zero |
| evt_flags | output | 16 | Internal event flags |
| irq_ps | output | 8 | Interrupt status, first destination |
| irq_pl | output | 8 | Interrupt status, second destination |

## Verification
The assertions check several properties in every cycle. A consumed flag is clear on the next edge, and a flag that is set and not consumed is still set on the next edge. An interrupt status bit is sticky unless it is cleared, and a raised status bit appears on the next edge. A released slot never pulses twice in a row, and a parked slot keeps its resource. Some behaviours only the bench scenarios can show: that the role bit routes a send-event to the right place, that several waiters are released together, that a second wait command is ignored, and that the two interrupt outputs agree. The bench shows these by comparing every output against a behavioural model in every cycle.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;

    // Per-thread wait slot states
    typedef enum logic {
        SLOT_IDLE   = 1'b0,
        SLOT_PARKED = 1'b1
    } slot_state_e;

    localparam int unsigned DEF_NUM_RES     = 16;
    localparam int unsigned DEF_NUM_IRQ     = 8;
    localparam int unsigned DEF_NUM_THREADS = 9;

endpackage

// File: rtl/dma_evt_cfg.sv
module dma_evt_cfg #(
    parameter int unsigned NUM_RES = 16,
    parameter int unsigned NUM_IRQ = 8,
    localparam int unsigned IDW    = $clog2(NUM_RES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_we,
    input  logic [NUM_IRQ-1:0] en_wdata,
    input  logic               irq_clr_we,
    input  logic [NUM_IRQ-1:0] irq_clr_mask,
    input  logic               sev_valid,
    input  logic [IDW-1:0]     sev_id,
    output logic [NUM_RES-1:0] en_rd,
    output logic [NUM_RES-1:0] ev_set,
    output logic [NUM_IRQ-1:0] irq_q
);

    logic [NUM_IRQ-1:0] en_q;
    logic [NUM_RES-1:0] sev_dec;
    logic [NUM_IRQ-1:0] irq_set;
    logic [NUM_IRQ-1:0] clr_eff;

    always_comb begin
        en_rd                = '0;
        en_rd[NUM_IRQ-1:0]   = en_q;
        sev_dec              = '0;
        if (sev_valid) begin
            sev_dec[sev_id]  = 1'b1;
        end
        ev_set  = sev_dec & ~en_rd;
        irq_set = sev_dec[NUM_IRQ-1:0] & en_q;
        clr_eff = irq_clr_we ? irq_clr_mask : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            irq_q <= '0;
        end else begin
            if (en_we) begin
                en_q <= en_wdata;
            end
            irq_q <= (irq_q & ~clr_eff) | irq_set;
        end
    end

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq_q & $past(irq_q & ~clr_eff)) == $past(irq_q & ~clr_eff))); // R5

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_set != '0) |=> ((irq_q & $past(irq_set)) == $past(irq_set))); // R3

endmodule

// File: rtl/dma_evt_flags.sv
module dma_evt_flags #(
    parameter int unsigned NUM_RES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_RES-1:0] ev_set,
    input  logic [NUM_RES-1:0] consume,
    output logic [NUM_RES-1:0] flag_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= (flag_q | ev_set) & ~consume;
        end
    end

    AST_CONSUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (consume != '0) |=> ((flag_q & $past(consume)) == '0)); // R8

    AST_SET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_set & ~consume) != '0) |=> ((flag_q & $past(ev_set & ~consume)) == $past(ev_set & ~consume))); // R1

endmodule

// File: rtl/dma_evt_slot.sv
module dma_evt_slot
    import dma_evt_pkg::*;
#(
    parameter int unsigned NUM_RES = 16,
    localparam int unsigned IDW    = $clog2(NUM_RES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [IDW-1:0]     go_id,
    input  logic [NUM_RES-1:0] flags,
    input  logic [NUM_RES-1:0] ev_set,
    output logic               done,
    output logic [NUM_RES-1:0] consume
);

    slot_state_e state_q, state_d;
    logic [IDW-1:0] id_q;
    logic hit;

    assign hit = flags[id_q] | ev_set[id_q];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_IDLE;
            id_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SLOT_IDLE && go) begin
                id_q <= go_id;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        done    = 1'b0;
        consume = '0;
        unique case (state_q)
            SLOT_IDLE: begin
                if (go) begin
                    state_d = SLOT_PARKED;          // park
                end
            end
            SLOT_PARKED: begin
                if (hit) begin
                    done          = 1'b1;
                    consume[id_q] = 1'b1;
                    state_d       = SLOT_IDLE;      // release
                end
            end
            default: state_d = SLOT_IDLE;
        endcase
    end

    AST_RELEASE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_PARKED_KEEPS_ID: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_PARKED && !done) |=> (id_q == $past(id_q))); // R9

endmodule

// File: rtl/dma_evt_unit.sv
module dma_evt_unit
    import dma_evt_pkg::*;
#(
    parameter int unsigned NUM_RES     = DEF_NUM_RES,
    parameter int unsigned NUM_IRQ     = DEF_NUM_IRQ,
    parameter int unsigned NUM_THREADS = DEF_NUM_THREADS,
    localparam int unsigned IDW        = $clog2(NUM_RES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en_we,
    input  logic [NUM_IRQ-1:0]         en_wdata,
    input  logic                       irq_clr_we,
    input  logic [NUM_IRQ-1:0]         irq_clr_mask,
    input  logic                       sev_valid,
    input  logic [IDW-1:0]             sev_id,
    input  logic [NUM_THREADS-1:0]     wfe_go,
    input  logic [NUM_THREADS*IDW-1:0] wfe_id,
    output logic [NUM_THREADS-1:0]     wfe_done,
    output logic [NUM_RES-1:0]         en_rd,
    output logic [NUM_RES-1:0]         evt_flags,
    output logic [NUM_IRQ-1:0]         irq_ps,
    output logic [NUM_IRQ-1:0]         irq_pl
);

    logic [NUM_RES-1:0] ev_set;
    logic [NUM_IRQ-1:0] irq_q;
    logic [NUM_RES-1:0] consume_s [NUM_THREADS];
    logic [NUM_RES-1:0] consume_all;

    dma_evt_cfg #(.NUM_RES(NUM_RES), .NUM_IRQ(NUM_IRQ)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_we        (en_we),
        .en_wdata     (en_wdata),
        .irq_clr_we   (irq_clr_we),
        .irq_clr_mask (irq_clr_mask),
        .sev_valid    (sev_valid),
        .sev_id       (sev_id),
        .en_rd        (en_rd),
        .ev_set       (ev_set),
        .irq_q        (irq_q)
    );

    generate
        for (genvar t = 0; t < NUM_THREADS; t++) begin : g_slot
            dma_evt_slot #(.NUM_RES(NUM_RES)) u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .go      (wfe_go[t]),
                .go_id   (wfe_id[t*IDW +: IDW]),
                .flags   (evt_flags),
                .ev_set  (ev_set),
                .done    (wfe_done[t]),
                .consume (consume_s[t])
            );
        end
    endgenerate

    always_comb begin
        consume_all = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            consume_all = consume_all | consume_s[t];
        end
    end

    dma_evt_flags #(.NUM_RES(NUM_RES)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_set  (ev_set),
        .consume (consume_all),
        .flag_q  (evt_flags)
    );

    assign irq_ps = irq_q;
    assign irq_pl = irq_q;

    AST_IRQ_ROLE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (sev_valid && en_rd[sev_id] && !evt_flags[sev_id]) |=> !evt_flags[$past(sev_id)]); // R3

    AST_EVENT_ROLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (sev_valid && !en_rd[sev_id] && !irq_clr_we) |=> (irq_ps == $past(irq_ps))); // R1

endmodule

// File: tb/test_dma_evt_unit.sv
module test_dma_evt_unit;

    localparam int NR = 16;
    localparam int NI = 8;
    localparam int NT = 9;
    localparam int IW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            en_we = 1'b0;
    logic [NI-1:0]   en_wdata = '0;
    logic            irq_clr_we = 1'b0;
    logic [NI-1:0]   irq_clr_mask = '0;
    logic            sev_valid = 1'b0;
    logic [IW-1:0]   sev_id = '0;
    logic [NT-1:0]   wfe_go = '0;
    logic [NT*IW-1:0] wfe_id = '0;
    logic [NT-1:0]   wfe_done;
    logic [NR-1:0]   en_rd;
    logic [NR-1:0]   evt_flags;
    logic [NI-1:0]   irq_ps;
    logic [NI-1:0]   irq_pl;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [NR-1:0] m_en = '0;
    logic [NR-1:0] m_flags = '0;
    logic [NI-1:0] m_irq = '0;
    bit            m_park [NT];
    int            m_pid  [NT];

    always #10 clk = ~clk;

    dma_evt_unit i_dma_evt_unit (
        .clk(clk), .rst_n(rst_n), .en_we(en_we), .en_wdata(en_wdata),
        .irq_clr_we(irq_clr_we), .irq_clr_mask(irq_clr_mask),
        .sev_valid(sev_valid), .sev_id(sev_id), .wfe_go(wfe_go), .wfe_id(wfe_id),
        .wfe_done(wfe_done), .en_rd(en_rd), .evt_flags(evt_flags),
        .irq_ps(irq_ps), .irq_pl(irq_pl)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [NT-1:0] exp_done();
        logic [NT-1:0] d = '0;
        for (int t = 0; t < NT; t++) begin
            if (m_park[t]) begin
                if (m_flags[m_pid[t]] ||
                    (sev_valid && int'(sev_id) == m_pid[t] && !m_en[sev_id]))
                    d[t] = 1'b1;
            end
        end
        return d;
    endfunction

    task automatic compare(string req);
        chk(req, "wfe_done", 64'(wfe_done), 64'(exp_done()));
        chk(req, "evt_flags", 64'(evt_flags), 64'(m_flags));
        chk(req, "en_rd", 64'(en_rd), 64'(m_en));
        chk(req, "irq_ps", 64'(irq_ps), 64'(m_irq));
        chk("R4", "irq_pl", 64'(irq_pl), 64'(irq_ps));
    endtask

    task automatic model_step();
        logic [NT-1:0] d = exp_done();
        logic [NR-1:0] setv = '0;
        logic [NR-1:0] cons = '0;
        logic [NI-1:0] iset = '0;
        logic [NI-1:0] clr = irq_clr_we ? irq_clr_mask : '0;
        if (sev_valid) begin
            if (m_en[sev_id]) iset[sev_id[2:0]] = 1'b1;
            else setv[sev_id] = 1'b1;
        end
        for (int t = 0; t < NT; t++) begin
            if (d[t]) begin
                cons[m_pid[t]] = 1'b1;
                m_park[t] = 1'b0;
            end else if (!m_park[t] && wfe_go[t]) begin
                m_park[t] = 1'b1;
                m_pid[t]  = int'(wfe_id[t*IW +: IW]);
            end
        end
        m_flags = (m_flags | setv) & ~cons;
        m_irq   = (m_irq & ~clr) | iset;
        if (en_we) m_en = {8'h00, en_wdata};
    endtask

    // inputs are set at a falling edge; compare before the rising edge
    task automatic tick(string req);
        #5;
        compare(req);
        @(posedge clk);
        model_step();
        @(negedge clk);
        en_we = 1'b0; irq_clr_we = 1'b0; irq_clr_mask = '0;
        sev_valid = 1'b0; wfe_go = '0;
    endtask

    task automatic send(int id);
        sev_valid = 1'b1;
        sev_id = IW'(id);
    endtask

    task automatic wait_cmd(int t, int id);
        wfe_go[t] = 1'b1;
        wfe_id[t*IW +: IW] = IW'(id);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int t = 0; t < NT; t++) begin m_park[t] = 0; m_pid[t] = 0; end
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "reset flags", 64'(evt_flags), 64'd0);
        chk("R10", "reset en", 64'(en_rd), 64'd0);
        chk("R10", "reset irq", 64'(irq_ps), 64'd0);
        chk("R10", "reset done", 64'(wfe_done), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: event role sets flags
        send(3);  tick("R1");
        send(15); tick("R1");
        tick("R1");
        chk("R1", "flags 3 and 15", 64'(evt_flags), 64'h8008);

        // R2: only low role bits stored
        en_we = 1'b1; en_wdata = 8'h0F; tick("R2");
        chk("R2", "en_rd", 64'(en_rd), 64'h000F);
        send(8); tick("R2");
        chk("R2", "flag 8", 64'(evt_flags[8]), 64'd1);

        // R3/R4: interrupt role
        send(2); tick("R3");
        chk("R3", "irq bit 2", 64'(irq_ps), 64'h04);
        chk("R3", "no flag 2", 64'(evt_flags[2]), 64'd0);
        chk("R4", "pl copy", 64'(irq_pl), 64'h04);

        // R5: sticky, clear, same-cycle set wins
        tick("R5"); tick("R5");
        chk("R5", "sticky", 64'(irq_ps), 64'h04);
        send(1); irq_clr_we = 1'b1; irq_clr_mask = 8'h06; tick("R5");
        chk("R5", "set wins, clear 2", 64'(irq_ps), 64'h02);
        irq_clr_mask = 8'h02; tick("R5"); // strobe low: no clear
        chk("R5", "mask without strobe", 64'(irq_ps), 64'h02);
        irq_clr_we = 1'b1; irq_clr_mask = 8'h02; tick("R5");
        chk("R5", "cleared", 64'(irq_ps), 64'h00);

        // R6: park then release on send; release on pending flag
        wait_cmd(0, 5); tick("R6");
        tick("R6");
        send(5); tick("R6");
        wait_cmd(1, 3); tick("R6");
        tick("R6");
        chk("R6", "flag 3 consumed", 64'(evt_flags[3]), 64'd0);

        // R7: several waiters on a pending flag
        wait_cmd(2, 15); wait_cmd(3, 15); tick("R7");
        tick("R7");
        chk("R7", "flag 15 cleared", 64'(evt_flags[15]), 64'd0);
        // R8: waiters released by a same-cycle send, flag stays clear
        wait_cmd(4, 6); wait_cmd(5, 6); tick("R8");
        send(6); tick("R8");
        chk("R8", "flag 6 clear", 64'(evt_flags[6]), 64'd0);

        // R9: second wait command ignored while parked
        wait_cmd(6, 10); tick("R9");
        wait_cmd(6, 11); tick("R9");
        send(11); tick("R9");
        tick("R9");
        chk("R9", "flag 11 left set", 64'(evt_flags[11]), 64'd1);
        send(10); tick("R9");
        tick("R9");

        // mixed traffic against the model
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 2) == 0) send($urandom_range(0, 15));
            for (int t = 0; t < NT; t++)
                if ($urandom_range(0, 5) == 0) wait_cmd(t, $urandom_range(0, 15));
            if ($urandom_range(0, 9) == 0) begin en_we = 1'b1; en_wdata = 8'($urandom); end
            if ($urandom_range(0, 4) == 0) begin irq_clr_we = 1'b1; irq_clr_mask = 8'($urandom); end
            tick("R6");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule